// File: doc/BRIEF.md
# Program Counter and Fetch Sequencer

This block chooses the program address for a small 8-bit controller core with a 12-bit instruction space. Each instruction cycle lasts four system clocks, T1 to T4. The block presents the fetch address in T1 and keeps it steady until T4. At the T4 edge it commits the next address. The next address comes from one of these sources: the increment, a jump or call target, a low-byte register write, the top of an 8-entry return stack, or one of six fixed interrupt vectors.

Fetch overlaps execution. While the instruction fetched in the previous cycle executes, the word at the current address is fetched. When the executing instruction redirects the flow or takes a skip, the word already fetched is thrown away. The block then flags the following cycle as a dummy slot, in which the decode inputs are ignored. The surrounding decoder drives one control strobe per cycle. The block answers an interrupt request only in an ordinary execute slot.

Top module: `pcseq_top`

## Requirements
- R1: While reset is low and in the first cycle after it is released, fetch_addr is 0x000, phase is 0 (T1), fetch_strobe is 1, exec_dummy is 1 and irq_ack is 0.
- R2: The phase output counts 0,1,2,3 and then wraps to 0. fetch_strobe is 1 only when phase is 0.
- R3: fetch_addr changes only at the clock edge that ends phase 3. In an ordinary slot with no control strobe it advances by 1, and 0xFFF wraps to 0x000.
- R4: With skip_taken sampled in an ordinary slot, fetch_addr advances by 1 and the next slot is a dummy slot. The instruction at the skip address plus 2 therefore runs two slots later.
- R5: With pcl_we, fetch_addr bits 7..0 become pcl_byte and bits 11..8 keep their value. The next slot is a dummy slot.
- R6: With op_jump, all 12 bits of fetch_addr become jump_target and the next slot is a dummy slot.
- R7: op_call loads jump_target and pushes the current fetch_addr, which is the call address plus 1. op_ret loads the most recently pushed value and removes it. Both make the next slot a dummy slot. If strobes coincide, the order of precedence is op_ret, then op_call, then op_jump, then pcl_we, then skip_taken.
- R8: The return stack holds 8 entries and wraps on overflow without any indication. After nine pushes, the first pop returns the ninth value and the second returns the eighth.
- R9: irq_req bit k selects the vector address 4*(k+1), giving 0x004 through 0x018. When several bits are set, the lowest bit wins. irq_ack is one-hot with the winning bit, during phase 3 of the accepting slot.
- R10: An interrupt is taken only in a slot that is not a dummy slot and carries no control strobe. Taking it pushes the current fetch_addr, loads the vector and makes the next slot a dummy slot. Otherwise the request waits.
- R11: In a dummy slot every control input and irq_req is ignored. fetch_addr advances by 1, and the following slot is ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| op_jump | input | 1 | Executing instruction is a jump |
| op_call | input | 1 | Executing instruction is a call |
| op_ret | input | 1 | Executing instruction is a return |
| pcl_we | input | 1 | Executing instruction writes the address low byte |
| pcl_byte | input | 8 | Byte written into the address low byte |
| jump_target | input | 12 | Address field of a jump or call |
| skip_taken | input | 1 | Conditional skip condition met |
| irq_req | input | 6 | Pending interrupt requests, bit k selects vector 4*(k+1) |
| fetch_addr | output | 12 | Program memory fetch address |
| fetch_strobe | output | 1 | High in T1, when fetch_addr is presented |
| phase | output | 2 | Current phase, 0 = T1 through 3 = T4 |
| exec_dummy | output | 1 | The current execute slot is a discarded, dummy slot |
| irq_ack | output | 6 | One-hot grant of the interrupt taken in this slot |

## Verification
Several kinds of input pattern are used, and each separates a different kind of error.

- **Interrupts:** all 63 non-zero irq_req masks are applied in turn. This separates a correct lowest-bit priority from any other order, and it catches wrong vector spacing.
- **Interrupts during a dummy slot:** each mask is first offered in a dummy slot. This shows whether requests are wrongly accepted there.
- **Low-byte writes:** these are swept over several byte values beneath different upper nibbles. This tells a low-byte merge apart from a full load.
- **Skips:** a skip followed by a jump in the dummy slot checks that the dummy slot really discards its inputs.
- **Stack:** nested calls and a nine-deep call chain distinguish correct last-in-first-out order from wrap errors.
- **Coinciding requests:** an interrupt raised together with a jump checks precedence.
- **Reset:** a second reset taken in the middle of the run checks the return to the reset state.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [2:0] {
      NX_INC  = 3'd0,
      NX_SKIP = 3'd1,
      NX_PCL  = 3'd2,
      NX_JUMP = 3'd3,
      NX_CALL = 3'd4,
      NX_RET  = 3'd5,
      NX_IRQ  = 3'd6
   } nxt_sel_t;

   function automatic logic redirects(nxt_sel_t s);
      return (s != NX_INC);
   endfunction

endpackage

// File: rtl/pcseq_phase.sv
module pcseq_phase #(
   parameter int NUM_PHASES = 4,
   parameter int PHASE_W    = $clog2(NUM_PHASES)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase,
   output logic               first,
   output logic               last
);
   localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(NUM_PHASES - 1);

   initial begin
      assert (NUM_PHASES >= 2) else $fatal(1, "NUM_PHASES must be at least 2");
      assert (PHASE_W >= $clog2(NUM_PHASES)) else $fatal(1, "PHASE_W too narrow");
   end

   logic [PHASE_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ph_q <= '0;
      else if (ph_q == LAST_PH) ph_q <= '0;
      else                     ph_q <= ph_q + 1'b1;
   end

   assign phase = ph_q;
   assign first = (ph_q == '0);
   assign last  = (ph_q == LAST_PH);

   assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> first);

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int AW    = 12,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top_data
);
   localparam int SP_W = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << SP_W) == DEPTH)
         else $fatal(1, "DEPTH must be a power of two");
   end

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_m1;
   logic [AW-1:0]   ent_q [DEPTH];

   assign sp_m1 = sp_q - SP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (push) begin
         ent_q[sp_q] <= push_data;
         sp_q        <= sp_q + SP_W'(1);
      end else if (pop) begin
         sp_q <= sp_m1;
      end
   end

   assign top_data = ent_q[sp_m1];

   assert_push_pop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   assert_push_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top_data == $past(push_data)));

endmodule

// File: rtl/pcseq_irq_sel.sv
module pcseq_irq_sel #(
   parameter int AW        = 12,
   parameter int NUM_IRQ   = 6,
   parameter int VEC_SHIFT = 2
) (
   input  logic [NUM_IRQ-1:0] req,
   output logic               any,
   output logic [NUM_IRQ-1:0] grant,
   output logic [AW-1:0]      vector
);
   initial begin
      assert (((NUM_IRQ + 1) << VEC_SHIFT) <= (1 << AW))
         else $fatal(1, "vector table exceeds address space");
   end

   always_comb begin
      grant  = '0;
      vector = '0;
      for (int k = NUM_IRQ - 1; k >= 0; k--) begin
         if (req[k]) begin
            grant    = '0;
            grant[k] = 1'b1;
            vector   = AW'((k + 1) << VEC_SHIFT);
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top #(
   parameter int AW          = 12,
   parameter int LOW_W       = 8,
   parameter int STACK_DEPTH = 8,
   parameter int NUM_IRQ     = 6,
   parameter int VEC_SHIFT   = 2,
   parameter int NUM_PHASES  = 4,
   parameter int PHASE_W     = $clog2(NUM_PHASES),
   parameter int RESET_ADDR  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_jump,
   input  logic               op_call,
   input  logic               op_ret,
   input  logic               pcl_we,
   input  logic [LOW_W-1:0]   pcl_byte,
   input  logic [AW-1:0]      jump_target,
   input  logic               skip_taken,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic [AW-1:0]      fetch_addr,
   output logic               fetch_strobe,
   output logic [PHASE_W-1:0] phase,
   output logic               exec_dummy,
   output logic [NUM_IRQ-1:0] irq_ack
);
   import pcseq_pkg::*;

   initial begin
      assert (LOW_W >= 1 && LOW_W <= AW) else $fatal(1, "LOW_W out of range");
      assert (RESET_ADDR >= 0 && RESET_ADDR < (1 << AW)) else $fatal(1, "RESET_ADDR out of range");
   end

   logic          t1, t4;
   logic [AW-1:0] pc_q, pc_inc, pc_nxt, pc_low_load, stk_top, vec_addr;
   logic          dummy_q, dummy_nxt;
   logic          irq_any, do_push, do_pop;
   logic [NUM_IRQ-1:0] irq_grant;
   nxt_sel_t      sel;

   pcseq_phase #(.NUM_PHASES(NUM_PHASES), .PHASE_W(PHASE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .phase(phase), .first(t1), .last(t4));

   pcseq_irq_sel #(.AW(AW), .NUM_IRQ(NUM_IRQ), .VEC_SHIFT(VEC_SHIFT)) u_irq (
      .req(irq_req), .any(irq_any), .grant(irq_grant), .vector(vec_addr));

   pcseq_stack #(.AW(AW), .DEPTH(STACK_DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
      .push_data(pc_q), .top_data(stk_top));

   generate
      if (LOW_W < AW) begin : g_low_merge
         assign pc_low_load = {pc_q[AW-1:LOW_W], pcl_byte};
      end else begin : g_low_full
         assign pc_low_load = AW'(pcl_byte);
      end
   endgenerate

   assign pc_inc = pc_q + AW'(1);

   always_comb begin
      if (dummy_q)          sel = NX_INC;
      else if (op_ret)      sel = NX_RET;
      else if (op_call)     sel = NX_CALL;
      else if (op_jump)     sel = NX_JUMP;
      else if (pcl_we)      sel = NX_PCL;
      else if (skip_taken)  sel = NX_SKIP;
      else if (irq_any)     sel = NX_IRQ;
      else                  sel = NX_INC;
   end

   always_comb begin
      dummy_nxt = redirects(sel);
      unique case (sel)
         NX_SKIP:          pc_nxt = pc_inc;
         NX_PCL:           pc_nxt = pc_low_load;
         NX_JUMP, NX_CALL: pc_nxt = jump_target;
         NX_RET:           pc_nxt = stk_top;
         NX_IRQ:           pc_nxt = vec_addr;
         default:          pc_nxt = pc_inc;
      endcase
   end

   assign do_push = t4 && (sel == NX_CALL || sel == NX_IRQ);
   assign do_pop  = t4 && (sel == NX_RET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= AW'(RESET_ADDR);
         dummy_q <= 1'b1;
      end else if (t4) begin
         pc_q    <= pc_nxt;
         dummy_q <= dummy_nxt;
      end
   end

   assign fetch_addr   = pc_q;
   assign fetch_strobe = t1;
   assign exec_dummy   = dummy_q;
   assign irq_ack      = (t4 && sel == NX_IRQ) ? irq_grant : '0;

   assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !t4 |=> $stable(pc_q));

   assert_dummy_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (t4 && dummy_q) |=> !dummy_q);

   assert_ack_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> (t4 && !dummy_q && !op_jump && !op_call && !op_ret && !pcl_we && !skip_taken));

   assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   assert_ack_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ack - 1'b1) & irq_req & {NUM_IRQ{|irq_ack}}) == '0);

   assert_jump_dummy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t4 && !dummy_q && op_jump) |=> dummy_q);

endmodule

// File: tb/pcseq_top_tb.sv
`timescale 1ns/1ps
module pcseq_top_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        op_jump = 0, op_call = 0, op_ret = 0, pcl_we = 0, skip_taken = 0;
   logic [7:0]  pcl_byte = 0;
   logic [11:0] jump_target = 0;
   logic [5:0]  irq_req = 0;
   logic [11:0] fetch_addr;
   logic        fetch_strobe;
   logic [1:0]  phase;
   logic        exec_dummy;
   logic [5:0]  irq_ack;

   int checks = 0, errors = 0;
   logic [11:0] exp_pc;
   logic        exp_dummy;
   logic [11:0] stk [8];
   int          sp;
   bit          done = 0;

   always #2.5 clk = ~clk;

   pcseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .op_jump(op_jump), .op_call(op_call), .op_ret(op_ret),
      .pcl_we(pcl_we), .pcl_byte(pcl_byte), .jump_target(jump_target),
      .skip_taken(skip_taken), .irq_req(irq_req), .fetch_addr(fetch_addr),
      .fetch_strobe(fetch_strobe), .phase(phase), .exec_dummy(exec_dummy),
      .irq_ack(irq_ack));

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(fetch_addr == 12'h000, "R1 addr in reset", fetch_addr, 0);
      chk(exec_dummy == 1'b1 && irq_ack == 6'd0, "R1 dummy/ack in reset", {exec_dummy, irq_ack}, 7'h40);
      rst_n = 1;
      exp_pc = 12'h000; exp_dummy = 1; sp = 0;
      for (int i = 0; i < 8; i++) stk[i] = 12'h000;
      chk(phase == 2'd0 && fetch_strobe, "R1 phase after release", {phase, fetch_strobe}, 1);
   endtask

   // One instruction slot: entered and left at the negedge inside T1.
   task automatic step(string req, bit j, bit c, bit r, bit pw, bit sk,
                       logic [7:0] pb, logic [11:0] tgt, logic [5:0] irq);
      logic [5:0] exp_ack;
      chk(fetch_addr == exp_pc, req, fetch_addr, exp_pc);
      chk(exec_dummy == exp_dummy, {req, " dummy"}, exec_dummy, exp_dummy);
      chk(fetch_strobe == 1'b1 && phase == 2'd0, "R2 T1 strobe", {phase, fetch_strobe}, 1);
      op_jump = j; op_call = c; op_ret = r; pcl_we = pw; skip_taken = sk;
      pcl_byte = pb; jump_target = tgt; irq_req = irq;
      exp_ack = 6'd0;
      if (!exp_dummy && !j && !c && !r && !pw && !sk && irq != 0)
         exp_ack = irq & (~irq + 6'd1);
      for (int p = 1; p < 4; p++) begin
         @(posedge clk); @(negedge clk);
         chk(phase == 2'(p) && !fetch_strobe, "R2 phase count", {phase, fetch_strobe}, p << 1);
         chk(fetch_addr == exp_pc, "R3 addr held", fetch_addr, exp_pc);
      end
      chk(irq_ack == exp_ack, "R9 R10 irq_ack", irq_ack, exp_ack);
      @(posedge clk); @(negedge clk);
      op_jump = 0; op_call = 0; op_ret = 0; pcl_we = 0; skip_taken = 0; irq_req = 0;
      // reference model
      if (exp_dummy) begin
         exp_pc = exp_pc + 12'd1; exp_dummy = 0;
      end else if (r) begin
         sp = (sp + 7) % 8; exp_pc = stk[sp]; exp_dummy = 1;
      end else if (c) begin
         stk[sp] = exp_pc; sp = (sp + 1) % 8; exp_pc = tgt; exp_dummy = 1;
      end else if (j) begin
         exp_pc = tgt; exp_dummy = 1;
      end else if (pw) begin
         exp_pc = {exp_pc[11:8], pb}; exp_dummy = 1;
      end else if (sk) begin
         exp_pc = exp_pc + 12'd1; exp_dummy = 1;
      end else if (irq != 0) begin
         int k = 0;
         while (!irq[k]) k++;
         stk[sp] = exp_pc; sp = (sp + 1) % 8;
         exp_pc = 12'((k + 1) * 4); exp_dummy = 1;
      end else begin
         exp_pc = exp_pc + 12'd1; exp_dummy = 0;
      end
   endtask

   task automatic idle(string req);
      step(req, 0, 0, 0, 0, 0, 8'h00, 12'h000, 6'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      idle("R11 first dummy slot");
      idle("R3 increment");
      idle("R3 increment");
      // skip, then a jump offered in the dummy slot must be dropped
      step("R4 skip", 0, 0, 0, 0, 1, 8'h00, 12'h000, 6'd0);
      step("R11 jump in dummy", 1, 0, 0, 0, 0, 8'h00, 12'h777, 6'd0);
      idle("R4 after skip");
      // low-byte writes under several upper nibbles
      for (int u = 0; u < 4; u++) begin
         step("R6 jump", 1, 0, 0, 0, 0, 8'h00, 12'(u * 12'h500 + 12'h0A3), 6'd0);
         idle("R6 dummy");
         for (int b = 0; b < 256; b += 51) begin
            step("R5 low byte", 0, 0, 0, 1, 0, 8'(b), 12'h000, 6'd0);
            idle("R5 dummy");
         end
      end
      // wrap at top of space
      step("R6 jump top", 1, 0, 0, 0, 0, 8'h00, 12'hFFE, 6'd0);
      idle("R6 dummy");
      idle("R3 at FFF");
      idle("R3 wrap");
      idle("R3 after wrap");
      // nested calls
      step("R7 call a", 0, 1, 0, 0, 0, 8'h00, 12'h200, 6'd0);
      idle("R7 dummy");
      step("R7 call b", 0, 1, 0, 0, 0, 8'h00, 12'h300, 6'd0);
      idle("R7 dummy");
      step("R7 ret+call precedence", 0, 1, 1, 0, 0, 8'h00, 12'h444, 6'd0);
      idle("R7 dummy");
      step("R7 ret", 0, 0, 1, 0, 0, 8'h00, 12'h000, 6'd0);
      idle("R7 dummy");
      idle("R7 after return");
      // overflow: nine calls, then two returns
      for (int n = 0; n < 9; n++) begin
         step("R8 call chain", 0, 1, 0, 0, 0, 8'h00, 12'(12'h400 + n * 16), 6'd0);
         idle("R8 dummy");
      end
      step("R8 pop ninth", 0, 0, 1, 0, 0, 8'h00, 12'h000, 6'd0);
      idle("R8 dummy");
      step("R8 pop eighth", 0, 0, 1, 0, 0, 8'h00, 12'h000, 6'd0);
      idle("R8 dummy");
      // interrupt sweep: offered in a dummy slot first, then in an ordinary slot
      step("R6 jump", 1, 0, 0, 0, 0, 8'h00, 12'h123, 6'd0);
      for (int m = 1; m < 64; m++) begin
         step("R10 irq in dummy", 0, 0, 0, 0, 0, 8'h00, 12'h000, 6'(m));
         step("R9 irq taken", 0, 0, 0, 0, 0, 8'h00, 12'h000, 6'(m));
         idle("R9 vector dummy");
         step("R9 vector ret", 0, 0, 1, 0, 0, 8'h00, 12'h000, 6'd0);
      end
      idle("R10 dummy");
      // interrupt with a jump: jump wins, request waits
      step("R10 irq with jump", 1, 0, 0, 0, 0, 8'h00, 12'h6A0, 6'b100100);
      idle("R10 dummy");
      step("R10 irq later", 0, 0, 0, 0, 0, 8'h00, 12'h000, 6'b100100);
      idle("R10 dummy");
      idle("R9 vector body");
      // reset in the middle of the run
      do_reset();
      idle("R1 slot after reset");
      idle("R1 first fetch advance");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule